// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block sits beside the bus interface of an agent on a multiplexed 32-bit address/data bus. It works out even parity over the address/data lines and the command/byte-enable lines together. When the local agent is the one driving the address/data lines, the block supplies the parity bit on the following clock. When the local agent is only listening, it compares the parity bit that arrives one clock after the data against the parity it computed itself.

A mismatch is reported one clock after the parity bit is checked. Where the report goes depends on the kind of cycle the data belonged to:

- A data phase of a transaction that a target has claimed, other than a special cycle, is reported on the data parity error line.
- An address phase, or the data phase of a special cycle, is reported on the system error line.

Reporting is the only action taken. Nothing is retried or corrected.

A small register write port controls the block. It sets an enable for each error line, and both enables come out of reset cleared. It also clears the two sticky status flags, using write-one-to-clear. The status flags record every detected error whether or not its pin is enabled.

Top module: `bus_parity_guard`

## Requirements
- R1: When `parOe` is high, `parOut` equals the XOR of all bits of `adIn` and `cbeIn` sampled on the previous clock edge, which is even parity.
- R2: `parOe` is high in the cycle after an edge at which `localDrive` was sampled high, and low otherwise.
- R3: A listening data cycle is one with `dataPhase`=1, `targetSel`=1, `specialCyc`=0 and `localDrive`=0. If the next cycle's `parIn` differs from the parity of that cycle, `perrOut` rises one cycle later provided the PERR enable is set. That is two edges after the data cycle. Matching parity raises nothing.
- R4: A listening cycle with `localDrive`=0 that is an address phase (`addrPhase`=1), or a data phase of a special cycle (`dataPhase`=1, `specialCyc`=1), is handled with the same timing. A parity mismatch raises `serrOut` provided the SERR enable is set.
- R5: No error is reported or recorded for a cycle the local agent drove, or for a data phase with `targetSel`=0.
- R6: Both enables are 0 after reset. While an enable is 0, its pin stays low but its status flag is still set by an error.
- R7: The write port is a `regWe` pulse with `regWdata`. Bit 0 is the PERR enable and bit 1 is the SERR enable; both are loaded on every write. Writing 1 to bit 2 clears `stsPerr` and writing 1 to bit 3 clears `stsSerr`. A status flag otherwise holds, and an error arriving at the same edge as its clear leaves the flag set.
- R8: `perrOe` is high in every cycle in which `perrOut` is high and in the cycle right after. `serrOe` is high exactly when `serrOut` is high.
- R9: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| adIn | input | 32 | Address/data lines as seen on the bus |
| cbeIn | input | 4 | Command/byte-enable lines as seen on the bus |
| parIn | input | 1 | Parity line as seen on the bus |
| localDrive | input | 1 | Local agent drives the address/data lines this cycle |
| addrPhase | input | 1 | This cycle is an address phase |
| dataPhase | input | 1 | This cycle carries a data transfer |
| specialCyc | input | 1 | The current transaction is a special cycle |
| targetSel | input | 1 | A target has claimed the current transaction |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 4 | Enables (bits 1:0) and status clear (bits 3:2) |
| parOut | output | 1 | Generated parity value |
| parOe | output | 1 | Drive enable for the parity line |
| perrOut | output | 1 | Data parity error asserted |
| perrOe | output | 1 | Drive enable for the data parity error line |
| serrOut | output | 1 | System error asserted |
| serrOe | output | 1 | Drive enable for the system error line |
| stsPerr | output | 1 | Sticky data parity error flag |
| stsSerr | output | 1 | Sticky system error flag |
| perrEnable | output | 1 | Current PERR enable |
| serrEnable | output | 1 | Current SERR enable |

## Verification
The bench first sends a bad parity bit after a claimed data phase while both enables are still off. A design that gated the status flag with the enable would leave `stsPerr` clear. Mismatches are then placed after an address phase, after a special-cycle data phase, after a cycle the local agent drove, and after an unclaimed data phase. A design that routed errors by the wrong phase would raise the wrong line, and one that checked its own driven data would report spurious errors. A clear is written on the same edge as a new error to catch a design that lets the clear win. Pseudo-random data with back-to-back good and bad parity exposes any compare that is off by one cycle.

// File: rtl/parity_guard_pkg.sv
package parity_guard_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic genEn;   // local agent drives AD: produce parity next cycle
    logic capEn;   // local agent listens: keep expected parity for the check
  } dpStrobe_t;

  // Control write data bit positions
  localparam int unsigned WB_PERR_EN  = 0;
  localparam int unsigned WB_SERR_EN  = 1;
  localparam int unsigned WB_PERR_CLR = 2;
  localparam int unsigned WB_SERR_CLR = 3;
  localparam int unsigned WB_WIDTH    = 4;

endpackage

// File: rtl/parity_guard_datapath.sv
module parity_guard_datapath
  import parity_guard_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [AD_W-1:0]          adIn,
  input  logic [AD_W/LANE_W-1:0]   cbeIn,
  input  logic                     parIn,
  input  dpStrobe_t                stb,
  output logic                     parOut,
  output logic                     parOe,
  output logic                     mismatch
);

  localparam int unsigned LANES = AD_W / LANE_W;

  logic [LANES-1:0] lanePar;
  logic             totPar;
  logic             expPar;

  // per-lane parity, each lane folded with its byte-enable bit
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanePar[g] = (^adIn[g*LANE_W +: LANE_W]) ^ cbeIn[g];
  end

  assign totPar = ^lanePar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parOut <= 1'b0;
      parOe  <= 1'b0;
      expPar <= 1'b0;
    end else begin
      parOe  <= stb.genEn;
      parOut <= stb.genEn ? totPar : 1'b0;
      if (stb.capEn) expPar <= totPar;
    end
  end

  // received parity for the previous cycle against the locally computed value
  assign mismatch = parIn ^ expPar;

endmodule

// File: rtl/parity_guard_control.sv
module parity_guard_control
  import parity_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                localDrive,
  input  logic                addrPhase,
  input  logic                dataPhase,
  input  logic                specialCyc,
  input  logic                targetSel,
  input  logic                regWe,
  input  logic [WB_WIDTH-1:0] regWdata,
  input  logic                mismatch,
  output dpStrobe_t           stb,
  output logic                perrOut,
  output logic                perrOe,
  output logic                serrOut,
  output logic                serrOe,
  output logic                stsPerr,
  output logic                stsSerr,
  output logic                perrEnable,
  output logic                serrEnable
);

  logic pendPerr, pendSerr;
  logic classPerr, classSerr;
  logic errPerr, errSerr;
  logic clrPerr, clrSerr;

  assign stb.genEn = localDrive;
  assign stb.capEn = !localDrive;

  // classification of the current cycle, checked next cycle
  assign classPerr = !localDrive && dataPhase && targetSel && !specialCyc;
  assign classSerr = !localDrive && (addrPhase || (dataPhase && specialCyc));

  assign errPerr = pendPerr && mismatch;
  assign errSerr = pendSerr && mismatch;

  assign clrPerr = regWe && regWdata[WB_PERR_CLR];
  assign clrSerr = regWe && regWdata[WB_SERR_CLR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendPerr   <= 1'b0;
      pendSerr   <= 1'b0;
      perrOut    <= 1'b0;
      perrOe     <= 1'b0;
      serrOut    <= 1'b0;
      serrOe     <= 1'b0;
      stsPerr    <= 1'b0;
      stsSerr    <= 1'b0;
      perrEnable <= 1'b0;
      serrEnable <= 1'b0;
    end else begin
      pendPerr <= classPerr;
      pendSerr <= classSerr;
      perrOut  <= errPerr && perrEnable;
      // keep driving one more cycle after assertion to return the line high
      perrOe   <= (errPerr && perrEnable) || perrOut;
      serrOut  <= errSerr && serrEnable;
      serrOe   <= errSerr && serrEnable;
      // new error outranks a simultaneous clear
      stsPerr  <= errPerr || (stsPerr && !clrPerr);
      stsSerr  <= errSerr || (stsSerr && !clrSerr);
      if (regWe) begin
        perrEnable <= regWdata[WB_PERR_EN];
        serrEnable <= regWdata[WB_SERR_EN];
      end
    end
  end

endmodule

// File: rtl/bus_parity_guard.sv
module bus_parity_guard
  import parity_guard_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned CBE_W = AD_W / LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AD_W-1:0]     adIn,
  input  logic [CBE_W-1:0]    cbeIn,
  input  logic                parIn,
  input  logic                localDrive,
  input  logic                addrPhase,
  input  logic                dataPhase,
  input  logic                specialCyc,
  input  logic                targetSel,
  input  logic                regWe,
  input  logic [WB_WIDTH-1:0] regWdata,
  output logic                parOut,
  output logic                parOe,
  output logic                perrOut,
  output logic                perrOe,
  output logic                serrOut,
  output logic                serrOe,
  output logic                stsPerr,
  output logic                stsSerr,
  output logic                perrEnable,
  output logic                serrEnable
);

  dpStrobe_t stb;
  logic      mismatch;

  parity_guard_datapath #(.AD_W(AD_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeIn(cbeIn), .parIn(parIn),
    .stb(stb), .parOut(parOut), .parOe(parOe), .mismatch(mismatch)
  );

  parity_guard_control u_ctl (
    .clk(clk), .rstN(rstN), .localDrive(localDrive), .addrPhase(addrPhase),
    .dataPhase(dataPhase), .specialCyc(specialCyc), .targetSel(targetSel),
    .regWe(regWe), .regWdata(regWdata), .mismatch(mismatch), .stb(stb),
    .perrOut(perrOut), .perrOe(perrOe), .serrOut(serrOut), .serrOe(serrOe),
    .stsPerr(stsPerr), .stsSerr(stsSerr),
    .perrEnable(perrEnable), .serrEnable(serrEnable)
  );

endmodule

// File: rtl/bus_parity_guard_checker.sv
module bus_parity_guard_checker #(
  parameter int unsigned AD_W = 32,
  parameter int unsigned CBE_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [AD_W-1:0]  adIn,
  input logic [CBE_W-1:0] cbeIn,
  input logic             localDrive,
  input logic             regWe,
  input logic             parOut,
  input logic             parOe,
  input logic             perrOut,
  input logic             perrOe,
  input logic             serrOut,
  input logic             serrOe,
  input logic             stsPerr,
  input logic             stsSerr
);

  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= 2'd0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R1: generated parity covers the previous cycle's lines
  a_r1_par_value: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1 && parOe) |-> parOut == $past(^{adIn, cbeIn}));

  // R2: drive enable follows the local-drive flag by one cycle
  a_r2_par_oe: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1) |-> parOe == $past(localDrive));

  // R3: a data parity report is always recorded in the sticky flag
  a_r3_perr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> stsPerr);

  // R4: a system error report is always recorded in the sticky flag
  a_r4_serr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> stsSerr);

  // R5: no report for a cycle the local agent drove
  a_r5_no_self_check: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && $past(localDrive, 2)) |-> !perrOut && !serrOut);

  // R7: sticky flags hold without a write
  a_r7_perr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1 && $past(stsPerr) && !$past(regWe)) |-> stsPerr);
  a_r7_serr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1 && $past(stsSerr) && !$past(regWe)) |-> stsSerr);

  // R8: PERR stays driven for one cycle after it drops
  a_r8_perr_release: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd1 && $fell(perrOut)) |-> perrOe);
  a_r8_perr_oe: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> perrOe);
  a_r8_serr_oe: assert property (@(posedge clk) disable iff (!rstN)
    serrOe == serrOut);

endmodule

bind bus_parity_guard bus_parity_guard_checker #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (.*);

// File: tb/bus_parity_guard_bench.sv
module bus_parity_guard_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeIn = '0;
  logic        parIn = 1'b0;
  logic        localDrive = 1'b0, addrPhase = 1'b0, dataPhase = 1'b0;
  logic        specialCyc = 1'b0, targetSel = 1'b0, regWe = 1'b0;
  logic [3:0]  regWdata = '0;
  logic        parOut, parOe, perrOut, perrOe, serrOut, serrOe;
  logic        stsPerr, stsSerr, perrEnable, serrEnable;

  always #10 clk = ~clk;  // 50 MHz

  bus_parity_guard u_bus_parity_guard (.*);

  typedef struct {
    logic  par, parEn, perr, perrE, serr, serrE, sP, sS, eP, eS;
    string tag;
  } exp_t;

  exp_t q[$];
  int   nChk = 0, nFail = 0;
  bit   done = 1'b0;

  // reference state
  logic mExp = 0, mPendP = 0, mPendS = 0, mEnP = 0, mEnS = 0;
  logic mStsP = 0, mStsS = 0, mPrevPerr = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // driver: drive one cycle, push the outputs expected after the coming edge
  task automatic drv(input logic [31:0] ad, input logic [3:0] cbe, input logic bad,
                     input logic ld, input logic ap, input logic dp, input logic sp,
                     input logic ts, input logic we, input logic [3:0] wd, input string tag);
    exp_t e;
    logic mis, eP, eS, cur;
    @(negedge clk);
    adIn = ad; cbeIn = cbe; parIn = mExp ^ bad;
    localDrive = ld; addrPhase = ap; dataPhase = dp; specialCyc = sp; targetSel = ts;
    regWe = we; regWdata = wd;
    cur = ^{ad, cbe};
    mis = bad;
    eP = mPendP & mis;
    eS = mPendS & mis;
    e.par = cur; e.parEn = ld;
    e.perr = eP & mEnP; e.perrE = (eP & mEnP) | mPrevPerr;
    e.serr = eS & mEnS; e.serrE = eS & mEnS;
    mStsP = eP | (mStsP & !(we & wd[2]));
    mStsS = eS | (mStsS & !(we & wd[3]));
    e.sP = mStsP; e.sS = mStsS;
    if (we) begin mEnP = wd[0]; mEnS = wd[1]; end
    e.eP = mEnP; e.eS = mEnS;
    e.tag = tag;
    mPrevPerr = e.perr;
    if (!ld) mExp = cur;
    mPendP = !ld & dp & ts & !sp;
    mPendS = !ld & (ap | (dp & sp));
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2", "parOe", parOe, e.parEn);
      if (e.parEn) chk("R1", "parOut", parOut, e.par);
      chk({e.tag, "/R3"}, "perrOut", perrOut, e.perr);
      chk({e.tag, "/R4"}, "serrOut", serrOut, e.serr);
      chk("R8", "perrOe", perrOe, e.perrE);
      chk("R8", "serrOe", serrOe, e.serrE);
      chk({e.tag, "/R7"}, "stsPerr", stsPerr, e.sP);
      chk({e.tag, "/R7"}, "stsSerr", stsSerr, e.sS);
      chk("R6", "perrEnable", perrEnable, e.eP);
      chk("R6", "serrEnable", serrEnable, e.eS);
    end
  end

  task automatic idle(input string tag);
    drv(32'h0, 4'h0, 1'b0, 0, 0, 0, 0, 0, 0, 4'h0, tag);
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "parOe", parOe, 1'b0);
    chk("R9", "perrOut", perrOut, 1'b0);
    chk("R9", "serrOut", serrOut, 1'b0);
    chk("R9", "stsPerr", stsPerr, 1'b0);
    chk("R9", "perrOe", perrOe, 1'b0);
    chk("R6", "perrEnable at reset", perrEnable, 1'b0);
    chk("R6", "serrEnable at reset", serrEnable, 1'b0);
    rstN = 1'b1;

    // R6: error with enables off: no pin, status set
    drv(32'hA5A5_0001, 4'h3, 0, 0, 0, 1, 0, 1, 0, 4'h0, "R6");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R6");
    idle("R6"); idle("R6");
    // clear status, enable both
    drv(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, "R7");
    idle("R7");
    // R3 good parity: nothing
    drv(32'h1234_5678, 4'h0, 0, 0, 0, 1, 0, 1, 0, 4'h0, "R3");
    drv(32'h0000_00FF, 4'hF, 0, 0, 0, 1, 0, 1, 0, 4'h0, "R3");
    // R3 bad parity on the second data word
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R3");
    idle("R3"); idle("R8"); idle("R8");
    // R4 address phase bad
    drv(32'hDEAD_BEEF, 4'h6, 0, 0, 1, 0, 0, 0, 0, 4'h0, "R4");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R4");
    idle("R4"); idle("R4");
    // R4 special cycle data phase bad
    drv(32'h0F0F_0F0F, 4'h1, 0, 0, 0, 1, 1, 0, 0, 4'h0, "R4");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R4");
    idle("R4");
    // clear both status flags, keep enables
    drv(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, "R7");
    idle("R7");
    // R5: local agent drives, bad parity follows: no report; R1 parity
    drv(32'hCAFE_F00D, 4'h9, 0, 1, 1, 0, 0, 0, 0, 4'h0, "R5");
    drv(32'h8000_0001, 4'h2, 1, 1, 0, 1, 0, 1, 0, 4'h0, "R5");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R5");
    // R5: data phase without a claimed target
    drv(32'h7777_7777, 4'h4, 0, 0, 0, 1, 0, 0, 0, 4'h0, "R5");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R5");
    idle("R5"); idle("R5");
    // R7: error arrives with its clear on the same edge: set wins
    drv(32'h1, 4'h0, 0, 0, 0, 1, 0, 1, 0, 4'h0, "R7");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 1, 4'h7, "R7");
    idle("R7"); idle("R7");
    // R6: disable PERR only, then error: status yes, pin no
    drv(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'h6, "R6");
    drv(32'h3, 4'h0, 0, 0, 0, 1, 0, 1, 0, 4'h0, "R6");
    drv(32'h0, 4'h0, 1, 0, 0, 0, 0, 0, 0, 4'h0, "R6");
    idle("R6");
    drv(32'h0, 4'h0, 0, 0, 0, 0, 0, 0, 1, 4'hF, "R7");
    // mixed pseudo-random burst, back-to-back good/bad
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drv(lfsr, lfsr[7:4], lfsr[9] & lfsr[3], lfsr[11] & lfsr[12], lfsr[13] & lfsr[14],
          lfsr[15], lfsr[16] & lfsr[17] & lfsr[18], lfsr[19] | lfsr[20], lfsr[22] & lfsr[23] & lfsr[24],
          lfsr[28:25], "R3");
    end
    idle("R3"); idle("R3");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule